// File: doc/BRIEF.md
# Word-Register Two-Wire Slave

This block is a slave on a two-wire SMBus/I2C-compatible bus that gives a host access to a bank of sixteen 16-bit registers. The register bank sits outside the block. The block presents the bank with a register index, a write word with a one-cycle write strobe, and a one-cycle read request. Each transfer moves one 16-bit word. A command byte selects the register, and the data goes most significant byte first.

SCL and SDA arrive as open-drain line levels. The block passes them through two-flop synchronisers and samples them on a fast system clock. From the synchronised levels it detects start, repeated-start and stop conditions and the clock edges. Its own SDA output is an enable that can only pull the line low. The seven-bit bus address has a fixed upper nibble of binary 0011, and the low three bits come from strap inputs, so eight of these slaves can share one bus.

A write is: start, address with R/W=0, command, data MSB, data LSB, stop. A read is: start, address with R/W=0, command, repeated start, address with R/W=1, then two bytes sent by the slave. The master acknowledges the first of these bytes and not-acknowledges the second. The slave reads the register word from the bank once, when the command byte is latched, and keeps that copy. Both bytes of a read therefore come from one consistent 16-bit value.

Top module: `smbus_word_slave`

## Requirements
- R1: The slave acknowledges (pulls SDA low during the ninth clock) an address byte whose upper seven bits equal binary 0011 followed by `addr_strap[2:0]`. Bit 0 of the address byte is R/W, where 0 means write and 1 means read. Any other address gets no acknowledge, and SDA stays released until the next start.
- R2: In a write, the command byte and both data bytes are each acknowledged. After the second data byte, `wr_stb` pulses for exactly one cycle. At that pulse, `reg_idx` equals command bits [3:0] (bits [7:4] are ignored) and `wr_data` is {first data byte, second data byte}.
- R3: When the command byte is latched, `rd_req` pulses for one cycle with `reg_idx` already valid. After a repeated start and an address byte with R/W=1, the slave sends `rd_data` as it stood during that pulse: bits [15:8] first, then bits [7:0], each byte MSB first. A change to `rd_data` after the pulse does not alter the word sent.
- R4: Indexes 8 to 14 are unused. A read of one of them returns 0000h whatever `rd_data` holds, and a write to one of them gives no `wr_stb`. Index 15 behaves like indexes 0 to 7.
- R5: If the master does not acknowledge the first read byte, the slave releases SDA for the rest of the transfer, and the host reads the second byte as FFh.
- R6: A start condition in the middle of a byte aborts the transfer and begins address matching again. A stop condition in the middle of a byte aborts the transfer and returns the slave to idle. Neither produces a `wr_stb`.
- R7: After reset the slave releases SDA and holds `wr_stb` and `rd_req` low. The SDA enable changes only while the synchronised SCL is low.
- R8: Bytes that follow the second data byte of a write are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| addr_strap | input | 3 | Low three bits of the slave address |
| sda_oe | output | 1 | When 1, the slave pulls SDA low |
| reg_idx | output | 4 | Register index taken from command bits [3:0] |
| wr_data | output | 16 | Word written by the host |
| wr_stb | output | 1 | One-cycle strobe: write `wr_data` to `reg_idx` |
| rd_req | output | 1 | One-cycle request: bank drives `rd_data` for `reg_idx` |
| rd_data | input | 16 | Register word from the bank, valid while `rd_req` is high |

## Verification
The hardest case to reach from the ports is a read in which the register word changes after the command byte has been accepted but before the data bytes go out. That change must not appear in the bytes the slave sends. The bench drives a repeated-start read and, in the gap between the command acknowledge and the repeated start, replaces the word the bank presents. It then checks that the old word comes out, and that a following read returns the new one. Mid-byte aborts are reached by clocking out only part of a byte and then issuing a start or a stop by hand.

// File: rtl/smbus_word_slave.sv
module smbus_word_slave #(
  parameter logic [3:0] ADDR_HI   = 4'b0011,
  parameter int         UNUSED_LO = 8,
  parameter int         UNUSED_HI = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [2:0]  addr_strap,
  output logic        sda_oe,
  output logic [3:0]  reg_idx,
  output logic [15:0] wr_data,
  output logic        wr_stb,
  output logic        rd_req,
  input  logic [15:0] rd_data
);
  localparam logic [2:0] P_IDLE = 3'd0, P_ADDR = 3'd1, P_CMD = 3'd2, P_WMSB = 3'd3,
                         P_WLSB = 3'd4, P_RMSB = 3'd5, P_RLSB = 3'd6, P_DONE = 3'd7;

  logic [2:0]  scl_sy, sda_sy;
  logic [2:0]  phase;
  logic [3:0]  cnt;
  logic [7:0]  sh, wr_msb;
  logic [15:0] snap;
  logic        rw, mack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end

  wire scl_s    = scl_sy[1];
  wire scl_q    = scl_sy[2];
  wire sda_s    = sda_sy[1];
  wire sda_q    = sda_sy[2];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  wire        unused_idx = (int'(reg_idx) >= UNUSED_LO) && (int'(reg_idx) <= UNUSED_HI);
  wire        addr_hit   = (sh[7:1] == {ADDR_HI, addr_strap});
  wire [7:0]  tx_byte    = (phase == P_RMSB) ? snap[15:8] : snap[7:0];
  wire [3:0]  bsel       = 4'd7 - cnt;
  wire        active     = (phase != P_IDLE) && (phase != P_DONE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase   <= P_IDLE;
      cnt     <= '0;
      sh      <= '0;
      wr_msb  <= '0;
      snap    <= '0;
      rw      <= 1'b0;
      mack    <= 1'b1;
      reg_idx <= '0;
      wr_data <= '0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      rd_req  <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      rd_req <= 1'b0;
      if (rd_req) snap <= unused_idx ? 16'h0000 : rd_data;
      if (start_c) begin
        phase  <= P_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        phase  <= P_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (active) begin
        if (scl_rise) begin
          if (cnt < 4'd8) sh <= {sh[6:0], sda_s};
          else            mack <= sda_s;
          if (cnt < 4'd9) cnt <= cnt + 4'd1;
        end else if (scl_fall) begin
          if (cnt == 4'd8) begin
            case (phase)
              P_ADDR: if (addr_hit) begin sda_oe <= 1'b1; rw <= sh[0]; end
                      else phase <= P_DONE;
              P_CMD:  begin sda_oe <= 1'b1; reg_idx <= sh[3:0]; rd_req <= 1'b1; end
              P_WMSB: begin sda_oe <= 1'b1; wr_msb <= sh; end
              P_WLSB: begin sda_oe <= 1'b1; wr_data <= {wr_msb, sh}; wr_stb <= ~unused_idx; end
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            case (phase)
              P_ADDR: if (rw) begin phase <= P_RMSB; sda_oe <= ~snap[15]; end
                      else    begin phase <= P_CMD;  sda_oe <= 1'b0; end
              P_CMD:  begin phase <= P_WMSB; sda_oe <= 1'b0; end
              P_WMSB: begin phase <= P_WLSB; sda_oe <= 1'b0; end
              P_RMSB: if (!mack) begin phase <= P_RLSB; sda_oe <= ~snap[7]; end
                      else       begin phase <= P_DONE; sda_oe <= 1'b0; end
              default: begin phase <= P_DONE; sda_oe <= 1'b0; end
            endcase
          end else if (cnt != 4'd0 && (phase == P_RMSB || phase == P_RLSB)) begin
            sda_oe <= ~tx_byte[bsel[2:0]];
          end
        end
      end
    end
endmodule

// File: rtl/smbus_word_slave_chk.sv
module smbus_word_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       wr_stb,
  input logic       rd_req,
  input logic [3:0] reg_idx,
  input logic [2:0] phase
);
  assert_stb_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  assert_no_unused_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !(reg_idx >= 4'd8 && reg_idx <= 4'd14));
  assert_idle_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0) |-> !sda_oe);
  assert_oe_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);
  assert_done_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd7) |-> !sda_oe);
endmodule

bind smbus_word_slave smbus_word_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .wr_stb(wr_stb),
  .rd_req(rd_req), .reg_idx(reg_idx), .phase(phase)
);

// File: tb/sim_smbus_word_slave.sv
`timescale 1ns/1ps
module sim_smbus_word_slave;
  localparam int Q = 8;
  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic [2:0] strap = 3'd0;
  logic sda_oe, wr_stb, rd_req;
  logic [3:0] reg_idx;
  logic [15:0] wr_data, rd_data;
  logic [15:0] bank [16];
  logic ovr_en = 0;
  logic [15:0] ovr_val = 0;
  int checks = 0, errors = 0, stb_cnt = 0, req_cnt = 0;
  logic [3:0] last_idx;
  logic [15:0] last_data;
  bit done = 0;

  always #2.5 clk = ~clk;
  wire sda_line = sda_m & ~sda_oe;
  assign rd_data = ovr_en ? ovr_val : bank[reg_idx];

  smbus_word_slave u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_strap(strap), .sda_oe(sda_oe), .reg_idx(reg_idx), .wr_data(wr_data),
    .wr_stb(wr_stb), .rd_req(rd_req), .rd_data(rd_data));

  always @(posedge clk) begin
    if (wr_stb) begin
      stb_cnt <= stb_cnt + 1; last_idx <= reg_idx; last_data <= wr_data;
      bank[reg_idx] <= wr_data;
    end
    if (rd_req) req_cnt <= req_cnt + 1;
  end

  task automatic chk(input bit ok, input string r, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", r, act, exp); end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1; wq(); scl_m = 1; wq(); ack = (sda_line == 1'b0); wq(); scl_m = 0; wq();
  endtask

  task automatic recv_byte(input bit m_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; wq(); scl_m = 1; wq(); b[i] = sda_line; wq(); scl_m = 0; wq();
    end
    sda_m = ~m_ack; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq(); sda_m = 1;
  endtask

  function automatic logic [15:0] wval(input int i);
    logic [3:0] n = 4'(i);
    return {n, ~n, n ^ 4'h5, 4'hA};
  endfunction

  task automatic wr_word(input logic [7:0] cmd, input logic [15:0] d, input string r);
    bit a;
    i2c_start();
    send_byte(8'h3A, a); chk(a, r, 16'(a), 1);
    send_byte(cmd, a);   chk(a, r, 16'(a), 1);
    send_byte(d[15:8], a); chk(a, r, 16'(a), 1);
    send_byte(d[7:0], a);  chk(a, r, 16'(a), 1);
    i2c_stop();
  endtask

  task automatic rd_word(input logic [7:0] cmd, output logic [15:0] d, input bit swap, input string r);
    bit a;
    i2c_start();
    send_byte(8'h3A, a); chk(a, r, 16'(a), 1);
    send_byte(cmd, a);   chk(a, r, 16'(a), 1);
    if (swap) begin ovr_val = 16'h0000; ovr_en = 1; end
    i2c_start();
    send_byte(8'h3B, a); chk(a, r, 16'(a), 1);
    recv_byte(1, d[15:8]);
    recv_byte(0, d[7:0]);
    i2c_stop();
  endtask

  initial begin
    bit a;
    logic [15:0] d;
    logic [7:0] b;
    int s0, r0;
    for (int i = 0; i < 16; i++) bank[i] = 16'h5A5A;
    repeat (5) @(negedge clk);
    chk(sda_oe == 0 && wr_stb == 0 && rd_req == 0, "R7 reset", {13'd0, sda_oe, wr_stb, rd_req}, 0);
    rst_n = 1; wq();

    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int ad = 0; ad < 8; ad++) begin
        i2c_start(); send_byte({4'b0011, 3'(ad), 1'b0}, a); i2c_stop();
        chk(a == (ad == s), "R1 address match", 16'(a), 16'(ad == s));
      end
    end
    strap = 3'd5;

    i2c_start(); send_byte(8'h90, a); chk(!a, "R1 foreign address", 16'(a), 0);
    send_byte(8'h3A, a); chk(!a, "R1 released until start", 16'(a), 0);
    i2c_stop();

    for (int i = 0; i < 16; i++) begin
      s0 = stb_cnt;
      wr_word({4'(i ^ 3), 4'(i)}, wval(i), "R2 write ack");
      if (i >= 8 && i <= 14)
        chk(stb_cnt == s0, "R4 unused write no strobe", 16'(stb_cnt - s0), 0);
      else begin
        chk(stb_cnt == s0 + 1, "R2 one strobe", 16'(stb_cnt - s0), 1);
        chk(last_idx == 4'(i) && last_data == wval(i), "R2 index and data", last_data, wval(i));
      end
    end

    for (int i = 0; i < 16; i++) begin
      r0 = req_cnt;
      rd_word(8'(i), d, 0, "R3 read ack");
      chk(req_cnt == r0 + 1, "R3 one read request", 16'(req_cnt - r0), 1);
      if (i >= 8 && i <= 14) chk(d == 16'h0000, "R4 unused reads zero", d, 16'h0000);
      else                   chk(d == wval(i), "R3 read word", d, wval(i));
    end

    rd_word(8'h02, d, 1, "R3 atomic ack");
    chk(d == wval(2), "R3 snapshot not torn", d, wval(2));
    rd_word(8'h02, d, 0, "R3 atomic ack");
    chk(d == 16'h0000, "R3 new word after change", d, 16'h0000);
    ovr_en = 0;

    i2c_start(); send_byte(8'h3A, a); send_byte(8'h01, a);
    i2c_start(); send_byte(8'h3B, a);
    recv_byte(0, b); chk(b == wval(1)[15:8], "R5 msb before nack", 16'(b), 16'(wval(1)[15:8]));
    recv_byte(0, b); chk(b == 8'hFF, "R5 released after nack", 16'(b), 16'h00FF);
    i2c_stop();

    i2c_start(); send_byte(8'h3A, a); send_byte(8'h04, a);
    send_byte(8'h11, a); send_byte(8'h22, a);
    send_byte(8'h33, a); chk(!a, "R8 extra byte not acked", 16'(a), 0);
    i2c_stop();
    chk(bank[4] == 16'h1122, "R8 word kept", bank[4], 16'h1122);

    s0 = stb_cnt;
    i2c_start(); send_byte(8'h3A, a); send_byte(8'h05, a); send_bits(8'hC3, 3); i2c_stop();
    chk(stb_cnt == s0, "R6 stop mid byte", 16'(stb_cnt - s0), 0);
    i2c_start(); send_byte(8'h3A, a); send_byte(8'h06, a); send_bits(8'hF0, 4);
    wr_word(8'h06, 16'hC0DE, "R6 restart ack");
    chk(stb_cnt == s0 + 1 && last_data == 16'hC0DE, "R6 start mid byte", last_data, 16'hC0DE);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule